// File: doc/BRIEF.md
# Dual 32-bit Programmable Timer

This peripheral holds two independent up-counters, half A and half B, behind a small register port. Each half has a counter that software can write, a period register and a two-bit enable field. With the enable field set to periodic, a half counts from zero up to its period, wraps to zero and pulses its interrupt once per lap. With a period of all ones this gives a free-running count that software can read at any time. With the enable field set to one-shot, a half counts from wherever it stands until it meets its period, pulses its interrupt once and then stops.

A global control register releases each half from reset and selects the operating mode. Only the dual independent mode is built, and any other mode value keeps both halves still. Half A can also carry a compare register. While half A counts, the compare register raises a separate event whenever the count equals the programmed value. Software arms it by writing the current count plus a delta, with modulo wraparound. The register port is single-cycle: a write lands at the clock edge that samples it, and read data is a combinational function of the address.

Top module: `dual_timer`

## Requirements
- R1: After synchronous reset every register reads zero and all three interrupt outputs are low.
- R2: Byte offsets are 0x10/0x14 for counter A/B, 0x18/0x1C for period A/B, 0x20 for control, 0x24 for global control and 0x60 for compare. Control keeps only bits 7:6 (mode A) and 23:22 (mode B). Global control keeps only bits 3:0. Counter, period and compare keep the low CNT_W bits. All other bits read zero. Unmapped or misaligned offsets read zero, and writes to them change nothing.
- R3: A half counts only when its release bit is 1 (bit 0 for A, bit 1 for B), global mode bits 3:2 equal 01, and its enable field is 01 or 10. Enable fields 00 and 11 mean stopped. A stopped half holds its count and raises no interrupt, and its registers still accept writes.
- R4: In periodic mode (10) the count rises by one per cycle. At the edge that finds count equal to period, the count becomes zero and the half's interrupt is high for the following cycle, so a period p gives one pulse every p+1 cycles.
- R5: In one-shot mode (01) the count rises by one per cycle, wrapping modulo 2^CNT_W, until it equals the period. It then pulses the interrupt for one cycle and holds the period value, and the enable field reads back unchanged.
- R6: After a one-shot stop, a write to the period register alone does not restart counting. A write to the counter or the control register does restart it.
- R7: A counter write takes effect at its edge even while running, and counting continues from the written value.
- R8: While half A counts, the compare event output is high for the cycle after any cycle in which count A equals the compare value, independent of period matching. A delta d written relative to a stopped count s fires d+1 cycles after the half is enabled, for every d from 1 to 2^CNT_W-2.
- R9: The two halves run independently, each with its own period and interrupt.
- R10: With an all-ones period in periodic mode the counter runs through every value and wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_a | output | 1 | Half A period or one-shot interrupt pulse |
| irq_b | output | 1 | Half B period or one-shot interrupt pulse |
| irq_cmp | output | 1 | Half A compare match event pulse |

## Verification
A register write lands at the edge that samples it and is visible on the read port half a cycle later, at the next falling edge. A half armed at edge E holds its start value until edge E+1. After n edges it shows start+n, or n mod (p+1) in periodic mode. The period interrupt is high after the edge that found count equal to period. In one-shot mode that is n = d+1, where d is the distance to the period. The compare event appears at n = delta+1 when the delta is measured from the stopped count. The bench counts edges from the arming write and samples both counter and interrupts at every falling edge after it. Each cycle is compared with these closed forms over sweeps of period, start value and delta on an 8-bit configuration.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int BUS_W = 32;
    localparam int OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_CNT_A = 8'h10;
    localparam logic [OFS_W-1:0] OFS_CNT_B = 8'h14;
    localparam logic [OFS_W-1:0] OFS_PRD_A = 8'h18;
    localparam logic [OFS_W-1:0] OFS_PRD_B = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h20;
    localparam logic [OFS_W-1:0] OFS_GCTL  = 8'h24;
    localparam logic [OFS_W-1:0] OFS_CMP_A = 8'h60;

    localparam int MODE_A_LSB    = 6;
    localparam int MODE_B_LSB    = 22;
    localparam int GCTL_REL_LSB  = 0;
    localparam int GCTL_MODE_LSB = 2;

    localparam logic [1:0] GMODE_UNCHAINED = 2'b01;

    localparam logic [BUS_W-1:0] CTRL_MASK = 32'h00C0_00C0;
    localparam logic [BUS_W-1:0] GCTL_MASK = 32'h0000_000F;

    typedef enum logic [1:0] {
        EN_OFF  = 2'b00,
        EN_ONCE = 2'b01,
        EN_LOOP = 2'b10,
        EN_RSV  = 2'b11
    } en_mode_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CNT_A,
        SEL_CNT_B,
        SEL_PRD_A,
        SEL_PRD_B,
        SEL_CTRL,
        SEL_GCTL,
        SEL_CMP
    } reg_sel_e;

    typedef struct packed {
        logic we_cnt;
        logic we_prd;
    } half_wr_t;

    typedef struct packed {
        en_mode_e mode;
        logic     released;
    } half_cfg_t;

    function automatic reg_sel_e decode_ofs(logic [OFS_W-1:0] ofs, logic cmp_present);
        reg_sel_e s;
        case (ofs)
            OFS_CNT_A: s = SEL_CNT_A;
            OFS_CNT_B: s = SEL_CNT_B;
            OFS_PRD_A: s = SEL_PRD_A;
            OFS_PRD_B: s = SEL_PRD_B;
            OFS_CTRL:  s = SEL_CTRL;
            OFS_GCTL:  s = SEL_GCTL;
            OFS_CMP_A: s = cmp_present ? SEL_CMP : SEL_NONE;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic mode_counts(en_mode_e m);
        return (m == EN_ONCE) || (m == EN_LOOP);
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctrl(en_mode_e ma, en_mode_e mb);
        logic [BUS_W-1:0] v;
        v = '0;
        v[MODE_A_LSB +: 2] = ma;
        v[MODE_B_LSB +: 2] = mb;
        return v;
    endfunction

endpackage

// File: rtl/dtm_half.sv
module dtm_half
    import dtm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  half_wr_t         wr,
    input  logic [CNT_W-1:0] wdata,
    input  half_cfg_t        cfg,
    input  logic             global_ok,
    input  logic             rearm,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd,
    output logic             running,
    output logic             irq
);

    logic expired;
    logic at_period;
    logic is_loop;

    assign is_loop   = (cfg.mode == EN_LOOP);
    assign at_period = (cnt == prd);
    assign running   = global_ok && cfg.released && mode_counts(cfg.mode) && !expired;

    // Counter and interrupt pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr.we_cnt) begin
                cnt <= wdata;
            end else if (running) begin
                if (at_period) begin
                    irq <= 1'b1;
                    if (is_loop) begin
                        cnt <= '0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Period register
    always_ff @(posedge clk) begin
        if (rst) begin
            prd <= '0;
        end else if (wr.we_prd) begin
            prd <= wdata;
        end
    end

    // One-shot stop flag, cleared by a counter or control write
    always_ff @(posedge clk) begin
        if (rst) begin
            expired <= 1'b0;
        end else if (wr.we_cnt || rearm) begin
            expired <= 1'b0;
        end else if (running && at_period && !is_loop) begin
            expired <= 1'b1;
        end
    end

endmodule

// File: rtl/dtm_cmp.sv
module dtm_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    output logic [CNT_W-1:0] cmp_val,
    output logic             irq
);

    logic match;

    assign match = run && (cnt == cmp_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val <= '0;
        end else if (we) begin
            cmp_val <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= match;
        end
    end

endmodule

// File: rtl/dtm_regfile.sv
module dtm_regfile
    import dtm_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [OFS_W-1:0]      bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    input  logic [1:0][CNT_W-1:0] cnt,
    input  logic [1:0][CNT_W-1:0] prd,
    input  logic [CNT_W-1:0]      cmp_val,
    output half_wr_t [1:0]        half_wr,
    output half_cfg_t [1:0]       half_cfg,
    output logic                  we_cmp,
    output logic                  we_ctrl,
    output logic                  global_ok
);

    reg_sel_e   rsel;
    reg_sel_e   wsel;
    en_mode_e   mode_a;
    en_mode_e   mode_b;
    logic [1:0] rel;
    logic [1:0] gmode;

    assign rsel = decode_ofs(bus_addr, HAS_CMP);
    assign wsel = bus_wr ? rsel : SEL_NONE;

    assign half_wr[0].we_cnt = (wsel == SEL_CNT_A);
    assign half_wr[0].we_prd = (wsel == SEL_PRD_A);
    assign half_wr[1].we_cnt = (wsel == SEL_CNT_B);
    assign half_wr[1].we_prd = (wsel == SEL_PRD_B);
    assign we_cmp            = (wsel == SEL_CMP);
    assign we_ctrl           = (wsel == SEL_CTRL);

    assign half_cfg[0].mode     = mode_a;
    assign half_cfg[0].released = rel[0];
    assign half_cfg[1].mode     = mode_b;
    assign half_cfg[1].released = rel[1];
    assign global_ok            = (gmode == GMODE_UNCHAINED);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_a <= EN_OFF;
            mode_b <= EN_OFF;
        end else if (we_ctrl) begin
            mode_a <= en_mode_e'(bus_wdata[MODE_A_LSB +: 2]);
            mode_b <= en_mode_e'(bus_wdata[MODE_B_LSB +: 2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel   <= '0;
            gmode <= '0;
        end else if (wsel == SEL_GCTL) begin
            rel   <= bus_wdata[GCTL_REL_LSB +: 2];
            gmode <= bus_wdata[GCTL_MODE_LSB +: 2];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            SEL_CNT_A: bus_rdata = BUS_W'(cnt[0]);
            SEL_CNT_B: bus_rdata = BUS_W'(cnt[1]);
            SEL_PRD_A: bus_rdata = BUS_W'(prd[0]);
            SEL_PRD_B: bus_rdata = BUS_W'(prd[1]);
            SEL_CTRL:  bus_rdata = pack_ctrl(mode_a, mode_b);
            SEL_GCTL:  bus_rdata = BUS_W'({gmode, rel});
            SEL_CMP:   bus_rdata = BUS_W'(cmp_val);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtm_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_a,
    output logic             irq_b,
    output logic             irq_cmp
);

    localparam int N_HALF = 2;

    logic [N_HALF-1:0][CNT_W-1:0] cnt_q;
    logic [N_HALF-1:0][CNT_W-1:0] prd_q;
    half_wr_t [N_HALF-1:0]        half_wr;
    half_cfg_t [N_HALF-1:0]       half_cfg;
    logic [N_HALF-1:0]            run;
    logic [N_HALF-1:0]            irq_half;
    logic [CNT_W-1:0]             cmp_val;
    logic                         we_cmp;
    logic                         we_ctrl;
    logic                         global_ok;

    dtm_regfile #(
        .CNT_W   (CNT_W),
        .HAS_CMP (HAS_CMP)
    ) i_regfile (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt_q),
        .prd       (prd_q),
        .cmp_val   (cmp_val),
        .half_wr   (half_wr),
        .half_cfg  (half_cfg),
        .we_cmp    (we_cmp),
        .we_ctrl   (we_ctrl),
        .global_ok (global_ok)
    );

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        dtm_half #(
            .CNT_W (CNT_W)
        ) i_half (
            .clk       (clk),
            .rst       (rst),
            .wr        (half_wr[h]),
            .wdata     (bus_wdata[CNT_W-1:0]),
            .cfg       (half_cfg[h]),
            .global_ok (global_ok),
            .rearm     (we_ctrl),
            .cnt       (cnt_q[h]),
            .prd       (prd_q[h]),
            .running   (run[h]),
            .irq       (irq_half[h])
        );
    end

    if (HAS_CMP) begin : g_cmp
        dtm_cmp #(
            .CNT_W (CNT_W)
        ) i_cmp (
            .clk     (clk),
            .rst     (rst),
            .we      (we_cmp),
            .wdata   (bus_wdata[CNT_W-1:0]),
            .cnt     (cnt_q[0]),
            .run     (run[0]),
            .cmp_val (cmp_val),
            .irq     (irq_cmp)
        );
    end else begin : g_no_cmp
        assign cmp_val = '0;
        assign irq_cmp = 1'b0;
    end

    assign irq_a = irq_half[0];
    assign irq_b = irq_half[1];

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
    import dtm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [OFS_W-1:0] bus_addr,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             run_a,
    input logic             run_b,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic [CNT_W-1:0] prd_a,
    input logic [CNT_W-1:0] prd_b,
    input logic [CNT_W-1:0] cmp_val,
    input logic             wcnt_a,
    input logic             wcnt_b,
    input logic             we_ctrl,
    input en_mode_e         mode_a,
    input en_mode_e         mode_b,
    input logic             irq_a,
    input logic             irq_b,
    input logic             irq_cmp
);

    // R2
    ctrl_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_CTRL) |-> ((bus_rdata & ~CTRL_MASK) == '0));

    // R3
    hold_a_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_a && !wcnt_a) |=> (cnt_a == $past(cnt_a)));

    // R3
    irq_a_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> $past(run_a));

    // R3
    irq_b_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> $past(run_b));

    // R4
    count_step_b_chk: assert property (@(posedge clk) disable iff (rst)
        (run_b && (cnt_b != prd_b) && !wcnt_b) |=> (cnt_b == CNT_W'($past(cnt_b) + 1'b1)));

    // R4
    reload_b_chk: assert property (@(posedge clk) disable iff (rst)
        (run_b && (mode_b == EN_LOOP) && (cnt_b == prd_b) && !wcnt_b) |=> ((cnt_b == '0) && irq_b));

    // R5
    oneshot_stop_a_chk: assert property (@(posedge clk) disable iff (rst)
        (run_a && (mode_a == EN_ONCE) && (cnt_a == prd_a) && !wcnt_a && !we_ctrl)
        |=> (irq_a && !run_a && $stable(cnt_a)));

    // R8
    cmp_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq_cmp |-> $past(run_a && (cnt_a == cmp_val)));

endmodule

bind dual_timer dual_timer_chk #(
    .CNT_W (CNT_W)
) i_dual_timer_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .run_a     (run[0]),
    .run_b     (run[1]),
    .cnt_a     (cnt_q[0]),
    .cnt_b     (cnt_q[1]),
    .prd_a     (prd_q[0]),
    .prd_b     (prd_q[1]),
    .cmp_val   (cmp_val),
    .wcnt_a    (half_wr[0].we_cnt),
    .wcnt_b    (half_wr[1].we_cnt),
    .we_ctrl   (we_ctrl),
    .mode_a    (half_cfg[0].mode),
    .mode_b    (half_cfg[1].mode),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .irq_cmp   (irq_cmp)
);

// File: tb/test_dual_timer.sv
module test_dual_timer;
    import dtm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;
    localparam int CMOD       = 1 << CW;

    localparam logic [BUS_W-1:0] G_RUN  = 32'h0000_0007;
    localparam logic [BUS_W-1:0] A_ONCE = 32'h0000_0040;
    localparam logic [BUS_W-1:0] A_LOOP = 32'h0000_0080;
    localparam logic [BUS_W-1:0] B_LOOP = 32'h0080_0000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic [OFS_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [BUS_W-1:0] bus_rdata;
    logic             irq_a;
    logic             irq_b;
    logic             irq_cmp;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_timer #(
        .CNT_W   (CW),
        .HAS_CMP (1'b1)
    ) i_dual_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_a     (irq_a),
        .irq_b     (irq_b),
        .irq_cmp   (irq_cmp)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [OFS_W-1:0] a, logic [BUS_W-1:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [OFS_W-1:0] a, output logic [BUS_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string req, logic [OFS_W-1:0] a, logic [BUS_W-1:0] exp);
        logic [BUS_W-1:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    // Periodic run of half B with period p (R4, R10)
    task automatic periodic_b(string req, int p, int span);
        wr(OFS_CTRL, '0);
        wr(OFS_CNT_B, '0);
        wr(OFS_PRD_B, 32'(p));
        wr(OFS_CTRL, B_LOOP);
        rd_chk(req, OFS_CNT_B, '0);
        chk(req, 32'(irq_b), 0);
        for (int n = 1; n <= span; n++) begin
            @(negedge clk);
            rd_chk(req, OFS_CNT_B, 32'(n % (p + 1)));
            chk(req, 32'(irq_b), 32'((n % (p + 1)) == 0));
        end
    endtask

    // Watch half A in one-shot from start s toward period p (R5)
    task automatic watch_once_a(string req, int s, int p);
        int d;
        int stepped;
        d = (p - s) & (CMOD - 1);
        for (int n = 0; n <= d + 4; n++) begin
            if (n > 0) @(negedge clk);
            stepped = (n < d) ? n : d;
            rd_chk(req, OFS_CNT_A, 32'((s + stepped) & (CMOD - 1)));
            chk(req, 32'(irq_a), 32'(n == d + 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [BUS_W-1:0] v;
        logic [BUS_W-1:0] held;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk("R1", OFS_CNT_A, '0);
        rd_chk("R1", OFS_CNT_B, '0);
        rd_chk("R1", OFS_PRD_A, '0);
        rd_chk("R1", OFS_PRD_B, '0);
        rd_chk("R1", OFS_CTRL,  '0);
        rd_chk("R1", OFS_GCTL,  '0);
        rd_chk("R1", OFS_CMP_A, '0);
        chk("R1", {29'd0, irq_a, irq_b, irq_cmp}, '0);

        // R2: field masks and readback
        wr(OFS_CTRL, '1);
        rd_chk("R2", OFS_CTRL, 32'h00C0_00C0);
        wr(OFS_GCTL, '1);
        rd_chk("R2", OFS_GCTL, 32'h0000_000F);
        wr(OFS_CNT_A, 32'hDEAD_BE5A);
        rd_chk("R2", OFS_CNT_A, 32'h0000_005A);
        wr(OFS_PRD_B, 32'h1234_5677);
        rd_chk("R2", OFS_PRD_B, 32'h0000_0077);
        wr(OFS_CMP_A, 32'hFFFF_FF3C);
        rd_chk("R2", OFS_CMP_A, 32'h0000_003C);
        // R2: unmapped and misaligned writes ignored, read zero
        wr(8'h30, '1);
        wr(8'h11, '1);
        wr(8'h21, '0);
        rd_chk("R2", 8'h30, '0);
        rd_chk("R2", 8'h11, '0);
        rd_chk("R2", OFS_CNT_A, 32'h0000_005A);
        rd_chk("R2", OFS_CTRL, 32'h00C0_00C0);
        rd_chk("R2", OFS_PRD_B, 32'h0000_0077);
        // R3: mode 11 with global mode 11 keeps count still
        repeat (4) @(negedge clk);
        rd_chk("R3", OFS_CNT_A, 32'h0000_005A);

        // R3: only half B released
        wr(OFS_CTRL, A_LOOP | B_LOOP);
        wr(OFS_GCTL, 32'h0000_0006);
        wr(OFS_PRD_A, 32'd3);
        wr(OFS_PRD_B, 32'd255);
        wr(OFS_CNT_A, 32'd5);
        wr(OFS_CNT_B, 32'd0);
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            rd_chk("R3", OFS_CNT_A, 32'd5);
            rd_chk("R3", OFS_CNT_B, 32'(n));
            chk("R3", 32'(irq_a), 0);
        end
        // R3: global mode 10 stops both halves
        wr(OFS_GCTL, 32'h0000_000B);
        rd(OFS_CNT_B, held);
        repeat (5) @(negedge clk);
        rd_chk("R3", OFS_CNT_B, held);
        // R3: enable field 11 is stopped
        wr(OFS_GCTL, G_RUN);
        wr(OFS_CTRL, 32'h00C0_00C0);
        rd(OFS_CNT_B, held);
        repeat (5) @(negedge clk);
        rd_chk("R3", OFS_CNT_B, held);
        chk("R3", {30'd0, irq_a, irq_b}, '0);

        // R4: periodic sweep on half B
        for (int p = 0; p < 16; p++) begin
            periodic_b("R4", p, 2 * (p + 1) + 2);
        end
        // R10: all-ones period wraps through every value
        periodic_b("R10", CMOD - 1, CMOD + 4);

        // R7: counter write while running
        wr(OFS_CNT_B, 32'd100);
        rd_chk("R7", OFS_CNT_B, 32'd100);
        repeat (3) @(negedge clk);
        rd_chk("R7", OFS_CNT_B, 32'd103);

        // R5: one-shot on half A, with wrap for start above period
        begin
            int starts [6] = '{0, 0, 0, 3, 250, 7};
            int prds   [6] = '{0, 1, 5, 9, 3, 7};
            for (int k = 0; k < 6; k++) begin
                wr(OFS_CTRL, '0);
                wr(OFS_CNT_A, 32'(starts[k]));
                wr(OFS_PRD_A, 32'(prds[k]));
                wr(OFS_CTRL, A_ONCE);
                watch_once_a("R5", starts[k], prds[k]);
                rd_chk("R5", OFS_CTRL, A_ONCE);
            end
        end

        // R6: period write alone does not restart (count held at 7)
        wr(OFS_PRD_A, 32'd10);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            rd_chk("R6", OFS_CNT_A, 32'd7);
            chk("R6", 32'(irq_a), 0);
        end
        // R6: control write restarts from the held count
        wr(OFS_CTRL, A_ONCE);
        watch_once_a("R6", 7, 10);
        // R6: counter write restarts as well
        wr(OFS_CNT_A, 32'd2);
        watch_once_a("R6", 2, 10);

        // R9: both halves at once with different periods
        wr(OFS_CTRL, '0);
        wr(OFS_CNT_A, '0);
        wr(OFS_PRD_A, 32'd4);
        wr(OFS_CNT_B, '0);
        wr(OFS_PRD_B, 32'd6);
        wr(OFS_CTRL, A_LOOP | B_LOOP);
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            rd_chk("R9", OFS_CNT_A, 32'(n % 5));
            rd_chk("R9", OFS_CNT_B, 32'(n % 7));
            chk("R9", 32'(irq_a), 32'((n % 5) == 0));
            chk("R9", 32'(irq_b), 32'((n % 7) == 0));
        end

        // R8: compare sweep over every delta, start values vary with wrap
        for (int dl = 1; dl <= CMOD - 2; dl++) begin
            int s;
            s = (dl * 37) & (CMOD - 1);
            wr(OFS_CTRL, '0);
            wr(OFS_PRD_A, 32'(CMOD - 1));
            wr(OFS_CNT_A, 32'(s));
            wr(OFS_CMP_A, 32'((s + dl) & (CMOD - 1)));
            wr(OFS_CTRL, A_LOOP);
            chk("R8", 32'(irq_cmp), 0);
            for (int n = 1; n <= dl + 2; n++) begin
                @(negedge clk);
                chk("R8", 32'(irq_cmp), 32'(n == dl + 1));
            end
        end

        // R8: compare stays quiet while half A is stopped
        wr(OFS_CTRL, '0);
        rd(OFS_CNT_A, v);
        wr(OFS_CMP_A, v);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk("R8", 32'(irq_cmp), 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule